// File: doc/BRIEF.md
# Free-Running Timer Counter Bank

This block is a set of ten up-counting timer counters for a microcontroller timer unit. Channel 0 holds one 32-bit counter. Channels 1 to 9 each hold a 16-bit counter. Each channel advances on a one-cycle count-enable pulse. A shared free-running divider generates that pulse, and each channel picks its own rate with a 2-bit select field. When a counter wraps to zero it sets a sticky overflow flag for its channel. Software clears a flag by writing 0 to its bit.

Software reaches everything over a 16-bit register bus. The bus is a single-cycle strobe with write data, and read data comes back combinationally in the same cycle. The 32-bit counter is only meaningful as a two-beat longword transfer, upper half first:
- A read of the upper half freezes a copy of the lower half, so the following lower-half read completes a coherent snapshot.
- A write of the upper half is parked in a staging register. The whole 32-bit value loads when the lower half is written.

Lower-half accesses that are not paired with an upper-half access do not disturb the counter.

Top module: `frt_bank`

## Requirements
- R1: After reset, the 32-bit counter holds 0. Each 16-bit counter of channel k holds 1 when bit k of parameter ONE_RST_MASK is set, and 0 otherwise. The default mask sets channels 7, 8 and 9.
- R2: On each count-enable pulse with no load in that cycle, a counter increases by exactly one. The 16-bit counters wrap from 0xFFFF to 0x0000 and the 32-bit counter wraps from 0xFFFFFFFF to 0. Without a pulse or load, a counter holds its value.
- R3: A channel's 2-bit select gives a pulse every cycle (0), every 2nd cycle (1), every 4th cycle (2) or every 8th cycle (3).
  - Channels 0 to 7 have their selects at address 12, channel k in bits [2k+1:2k].
  - Channels 8 and 9 have theirs at address 13, in bits [1:0] and [3:2].
  - Selects reset to 0 and read back as written.
- R4: A wrap of channel k's counter sets bit k of the flag register at address 11 on the same clock edge.
- R5: Writing the flag register clears each flag whose data bit is 0. Bits written as 1 leave their flags unchanged. A wrap in the same cycle as a clear keeps the flag set.
- R6: A read of address 0 returns the current upper half of the 32-bit counter and captures the lower half at that edge. A later read of address 1 returns the captured value.
- R7: A write to address 0 is staged without changing the counter. The next write to address 1, with no other longword access in between, loads {staged, written} into the 32-bit counter, and that load takes priority over counting.
- R8: A write to address 1 that is not armed by an earlier write to address 0 is ignored. A read of address 0 in between also disarms it. A lone read of address 1 returns the last captured lower half.
- R9: A write to address k+1 (k from 1 to 9) loads channel k's 16-bit counter at once, taking priority over counting.
- R10: bus_rdata is 0 in any cycle without a read, and when addresses 14 or 15 are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |

## Verification
On every cycle, the assertions check the following:
- Loads take priority over counting, and a counter steps by exactly one only on a pulse.
- A divided pulse is never followed by another pulse.
- A wrap always leaves its flag set.
- A clear without a wrap drops the flag.
- An upper-half read captures the lower half.

Only the bench scenarios can show the things that depend on a sequence of bus accesses:
- a coherent snapshot taken across a carry;
- the exact number of pulses per divider setting;
- the reset values seen through the bus;
- that lone or disarmed lower-half writes leave the counter's value untouched.

// File: rtl/frt_pkg.sv
`timescale 1ns/1ps
package frt_pkg;

  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {
    DIV_1 = 2'd0,
    DIV_2 = 2'd1,
    DIV_4 = 2'd2,
    DIV_8 = 2'd3
  } div_sel_e;

  // Count-enable for one channel given its select and the shared phase.
  function automatic logic tick_from(input logic [1:0] sel, input logic [PHASE_W-1:0] ph);
    case (div_sel_e'(sel))
      DIV_1:   return 1'b1;
      DIV_2:   return ph[0];
      DIV_4:   return &ph[1:0];
      default: return &ph;
    endcase
  endfunction

  // Sticky flag update: a wrap always wins over a clear.
  function automatic logic flag_next(input logic cur, input logic wrap,
                                     input logic clr_we, input logic clr_bit);
    return wrap | (cur & ~(clr_we & ~clr_bit));
  endfunction

endpackage

// File: rtl/frt_prescaler.sv
`timescale 1ns/1ps
module frt_prescaler #(
  parameter int NUM_CH = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NUM_CH-1:0]   sel_flat,
  output logic [NUM_CH-1:0]     tick
);
  logic [frt_pkg::PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_tick
    assign tick[k] = frt_pkg::tick_from(sel_flat[2*k +: 2], phase);

    // A divided pulse lasts one cycle (any nonzero select).
    assert_divided_tick_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[k] && sel_flat[2*k +: 2] != 2'd0) |=> (!tick[k] || sel_flat[2*k +: 2] == 2'd0));
  end
endmodule

// File: rtl/frt_counter.sv
`timescale 1ns/1ps
module frt_counter #(
  parameter int          WIDTH   = 16,
  parameter logic [31:0] RST_VAL = 32'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] cnt,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= RST_VAL[WIDTH-1:0];
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign wrap = tick & ~load & (&cnt);

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> cnt == WIDTH'($past(cnt) + 1'b1));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/frt_flags.sv
`timescale 1ns/1ps
module frt_flags #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] wrap,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_data,
  output logic [NUM_CH-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      for (int k = 0; k < NUM_CH; k++)
        flags[k] <= frt_pkg::flag_next(flags[k], wrap[k], clr_we, clr_data[k]);
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[k] |=> flags[k]);

    assert_clear_drops_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !clr_data[k] && !wrap[k]) |=> !flags[k]);
  end
endmodule

// File: rtl/frt_wide_access.sv
`timescale 1ns/1ps
module frt_wide_access #(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hi_rd,
  input  logic               hi_wr,
  input  logic               lo_rd,
  input  logic               lo_wr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [BUS_W-1:0]   cnt_lo,
  output logic [BUS_W-1:0]   lo_snap,
  output logic               load,
  output logic [2*BUS_W-1:0] load_val
);
  logic             armed;
  logic [BUS_W-1:0] staged_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      staged_hi <= '0;
      lo_snap   <= '0;
    end else begin
      if (hi_wr) begin
        armed     <= 1'b1;
        staged_hi <= wdata;
      end else if (hi_rd || lo_rd || lo_wr) begin
        armed <= 1'b0;
      end
      if (hi_rd) lo_snap <= cnt_lo;
    end
  end

  assign load     = lo_wr & armed;
  assign load_val = {staged_hi, wdata};

  assert_snapshot_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> lo_snap == $past(cnt_lo));

  assert_paired_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && $past(hi_wr)) |-> load);

  assert_unpaired_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && $past(hi_rd)) |-> !load);
endmodule

// File: rtl/frt_bank.sv
`timescale 1ns/1ps
module frt_bank #(
  parameter int              NUM_CH       = 10,
  parameter int              BUS_W        = 16,
  parameter int              ADDR_W       = 4,
  parameter logic [NUM_CH-1:0] ONE_RST_MASK = 10'b11_1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int WIDE_W         = 2 * BUS_W;
  localparam int HI_ADDR        = 0;
  localparam int LO_ADDR        = 1;
  localparam int FLAG_ADDR      = NUM_CH + 1;
  localparam int SEL_BASE       = NUM_CH + 2;
  localparam int FIELDS_PER_REG = BUS_W / 2;

  logic rd, wr;
  assign rd = bus_sel & ~bus_wr;
  assign wr = bus_sel & bus_wr;

  logic hi_rd, hi_wr, lo_rd, lo_wr, flag_we;
  assign hi_rd   = rd && bus_addr == ADDR_W'(HI_ADDR);
  assign hi_wr   = wr && bus_addr == ADDR_W'(HI_ADDR);
  assign lo_rd   = rd && bus_addr == ADDR_W'(LO_ADDR);
  assign lo_wr   = wr && bus_addr == ADDR_W'(LO_ADDR);
  assign flag_we = wr && bus_addr == ADDR_W'(FLAG_ADDR);

  // Divider select fields
  logic [2*NUM_CH-1:0] sel_flat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_flat <= '0;
    else if (wr) begin
      for (int k = 0; k < NUM_CH; k++)
        if (bus_addr == ADDR_W'(SEL_BASE + k / FIELDS_PER_REG))
          sel_flat[2*k +: 2] <= bus_wdata[2*(k % FIELDS_PER_REG) +: 2];
    end
  end

  logic [NUM_CH-1:0] tick;
  frt_prescaler #(.NUM_CH(NUM_CH)) u_presc (
    .clk(clk), .rst_n(rst_n), .sel_flat(sel_flat), .tick(tick)
  );

  // Wide channel 0
  logic [WIDE_W-1:0] wide_cnt, wide_load_val;
  logic [BUS_W-1:0]  lo_snap;
  logic              wide_load;
  logic [NUM_CH-1:0] wrap_vec;

  frt_wide_access #(.BUS_W(BUS_W)) u_wide_acc (
    .clk(clk), .rst_n(rst_n),
    .hi_rd(hi_rd), .hi_wr(hi_wr), .lo_rd(lo_rd), .lo_wr(lo_wr),
    .wdata(bus_wdata), .cnt_lo(wide_cnt[BUS_W-1:0]),
    .lo_snap(lo_snap), .load(wide_load), .load_val(wide_load_val)
  );

  frt_counter #(.WIDTH(WIDE_W), .RST_VAL(32'd0)) u_wide_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick[0]), .load(wide_load),
    .load_val(wide_load_val), .cnt(wide_cnt), .wrap(wrap_vec[0])
  );

  // Narrow channels 1..NUM_CH-1, channel k at address k+1
  logic [BUS_W-1:0] ncnt [NUM_CH-1:1];
  for (genvar k = 1; k < NUM_CH; k++) begin : g_narrow
    logic nload;
    assign nload = wr && bus_addr == ADDR_W'(k + 1);
    frt_counter #(.WIDTH(BUS_W), .RST_VAL(32'(ONE_RST_MASK[k]))) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick[k]), .load(nload),
      .load_val(bus_wdata), .cnt(ncnt[k]), .wrap(wrap_vec[k])
    );
  end

  logic [NUM_CH-1:0] flags;
  frt_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_vec), .clr_we(flag_we),
    .clr_data(bus_wdata[NUM_CH-1:0]), .flags(flags)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == ADDR_W'(HI_ADDR))   bus_rdata = wide_cnt[WIDE_W-1:BUS_W];
      if (bus_addr == ADDR_W'(LO_ADDR))   bus_rdata = lo_snap;
      if (bus_addr == ADDR_W'(FLAG_ADDR)) bus_rdata = BUS_W'(flags);
      for (int k = 1; k < NUM_CH; k++)
        if (bus_addr == ADDR_W'(k + 1)) bus_rdata = ncnt[k];
      for (int k = 0; k < NUM_CH; k++)
        if (bus_addr == ADDR_W'(SEL_BASE + k / FIELDS_PER_REG))
          bus_rdata[2*(k % FIELDS_PER_REG) +: 2] = sel_flat[2*k +: 2];
    end
  end

  assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> bus_rdata == '0);
endmodule

// File: tb/frt_bank_tb.sv
`timescale 1ns/1ps
module frt_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  frt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus beat: driven after a falling edge, sampled 1 ns later.
  task automatic op(input logic s, input logic w, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1 rv = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, 4'd0, 16'h0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // Beat i sees i+1 edges after release at divide-by-1.
    op(1, 0, 4'd0, 0); check("R1 wide high", rv, 16'h0000);
    op(1, 0, 4'd1, 0); check("R1 wide low snap", rv, 16'h0001);
    for (int k = 1; k < 10; k++) begin
      op(1, 0, 4'(k + 1), 0);
      check($sformatf("R1 ch%0d reset", k), rv, 16'((k >= 7 ? 1 : 0) + k + 2));
    end
    op(1, 0, 4'd12, 0); check("R3 select reset", rv, 16'h0000);
    op(0, 0, 4'd2, 0);  check("R10 idle rdata", rv, 16'h0000);
    op(1, 0, 4'd14, 0); check("R10 unmapped 14", rv, 16'h0000);
    op(1, 0, 4'd15, 0); check("R10 unmapped 15", rv, 16'h0000);
  endtask

  task automatic t_narrow;
    op(1, 1, 4'd4, 16'h1234);
    op(1, 0, 4'd4, 0); check("R9 narrow load", rv, 16'h1234);
    idle(5);
    op(1, 0, 4'd4, 0); check("R2 narrow count", rv, 16'h123A);
  endtask

  task automatic t_narrow_wrap;
    op(1, 1, 4'd2, 16'hFFFE);
    idle(1);
    op(1, 1, 4'd11, 16'hFFFD);          // clear ch1 flag in its wrap cycle
    op(1, 0, 4'd11, 0); check("R5 wrap beats clear", rv & 16'h0002, 16'h0002);
    op(1, 1, 4'd11, 16'hFFFD);
    op(1, 0, 4'd11, 0); check("R5 clear ch1", rv & 16'h0002, 16'h0000);
    op(1, 0, 4'd2, 0);  check("R2 narrow wrap to zero", rv, 16'h0003);
  endtask

  task automatic t_wide_wrap;
    op(1, 1, 4'd0, 16'hFFFF);
    op(1, 1, 4'd1, 16'hFFFE);
    idle(2);
    op(1, 0, 4'd11, 0); check("R4 wide overflow flag", rv & 16'h0001, 16'h0001);
    op(1, 1, 4'd11, 16'hFFFF);
    op(1, 0, 4'd11, 0); check("R5 write one keeps", rv & 16'h0001, 16'h0001);
    op(1, 1, 4'd11, 16'hFFFE);
    op(1, 0, 4'd11, 0); check("R5 write zero clears", rv & 16'h0001, 16'h0000);
  endtask

  task automatic t_wide_write;
    op(1, 1, 4'd0, 16'h5555);
    idle(2);
    op(1, 1, 4'd1, 16'h0000);
    op(1, 0, 4'd0, 0); check("R7 staged high loaded", rv, 16'h5555);
    op(1, 0, 4'd1, 0); check("R7 low loaded", rv, 16'h0000);
  endtask

  task automatic t_coherent;
    op(1, 1, 4'd0, 16'h0001);
    op(1, 1, 4'd1, 16'hFFFF);
    op(1, 0, 4'd0, 0); check("R6 snapshot high", rv, 16'h0001);
    op(1, 0, 4'd1, 0); check("R6 snapshot low", rv, 16'hFFFF);
    op(1, 0, 4'd1, 0); check("R8 lone low read", rv, 16'hFFFF);
    op(1, 0, 4'd0, 0); check("R6 high after carry", rv, 16'h0002);
    op(1, 0, 4'd1, 0); check("R6 low after carry", rv, 16'h0002);
  endtask

  task automatic t_lone_write;
    op(1, 1, 4'd0, 16'h0000);
    op(1, 1, 4'd1, 16'h0010);
    op(1, 1, 4'd1, 16'hABCD);           // not armed: ignored
    op(1, 0, 4'd0, 0); check("R8 high after lone write", rv, 16'h0000);
    op(1, 0, 4'd1, 0); check("R8 low after lone write", rv, 16'h0011);
    op(1, 1, 4'd0, 16'h7777);
    op(1, 0, 4'd0, 0);                  // read disarms the staged write
    op(1, 1, 4'd1, 16'h1234);
    op(1, 0, 4'd0, 0); check("R8 disarmed by high read", rv, 16'h0000);
  endtask

  task automatic presc_case(input logic [3:0] sel_addr, input logic [15:0] sel_val,
                            input logic [3:0] ch_addr, input logic [15:0] exp, input string tag);
    op(1, 1, sel_addr, sel_val);
    op(1, 1, ch_addr, 16'h0100);
    idle(16);
    op(1, 0, ch_addr, 0); check(tag, rv, exp);
  endtask

  task automatic t_prescale;
    presc_case(4'd12, 16'h0020, 4'd3, 16'h0104, "R3 div4 ch2");
    op(1, 0, 4'd12, 0); check("R3 select readback", rv, 16'h0020);
    presc_case(4'd12, 16'h0030, 4'd3, 16'h0102, "R3 div8 ch2");
    presc_case(4'd12, 16'h0010, 4'd3, 16'h0108, "R3 div2 ch2");
    presc_case(4'd13, 16'h0008, 4'd10, 16'h0104, "R3 div4 ch9");
    op(1, 0, 4'd13, 0); check("R3 select readback ch9", rv, 16'h0008);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_narrow_wrap();
    t_wide_wrap();
    t_wide_write();
    t_coherent();
    t_lone_write();
    t_prescale();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule